// File: doc/BRIEF.md
# Debug Access Security Filter

This block stands on the path between an external debug port's bus master and the system bus. Each access it receives is decoded against the debug unit's address range. A protection flag decides what happens next. With the flag clear, every access is forwarded after one registered decode stage. With the flag set, a debugger access is forwarded only if its offset lies inside a fixed window of the debug unit's range. Any other debugger access never reaches the bus and ends with a two-cycle error response, which the debug port latches as a sticky error. Accesses marked as coming from the CPU are always forwarded.

The debug register block is decoded at two aliases: a low view used by the CPU and an upper view used by the debugger. The forwarded access carries the register offset and a flag that names the view used. The protection flag is loaded from a non-volatile input during reset and is set by a one-cycle pulse. Only a full erase clears it. The erase wipes volatile memory first and then flash, and the flag drops when the flash wipe finishes. While the flag is set, two debug features are restricted. A request to clear the CPU reset extension is refused. A hot-plug debugger attach is refused, while a cold-plug attach is still granted.

Top module: `dbg_sec_filter`

## Requirements
- R1: For a forwarded access whose offset from `DSU_BASE` is below 0x200, `reg_hit_o` is 1, `reg_ofs_o` equals offset bits [7:0], and `reg_ext_o` equals offset bit 8 (0 for the CPU view 0x000–0x0FF, 1 for the debugger view 0x100–0x1FF). For any other forwarded access all three are 0.
- R2: While protected, a debugger access (`acc_cpu_i`=0) is forwarded only if its offset from `DSU_BASE` is at least 0x100 and below 0x2000. Offset 0x0FF is blocked, 0x100 passes, 0x1FFF passes, and 0x2000 or any address outside the range is blocked.
- R3: A blocked access never drives `bus_valid_o`. In the cycle after it is accepted, `acc_ready_o`=0 and `acc_err_o`=1. In the cycle after that, `acc_ready_o`=1 and `acc_err_o`=1. Outside an error response `acc_ready_o`=1 and `acc_err_o`=0.
- R4: A request presented while `acc_ready_o` is 0 is ignored.
- R5: An access with `acc_cpu_i`=1 is always forwarded, whether or not the device is protected.
- R6: An accepted access that is allowed appears on `bus_valid_o`, `bus_addr_o` and `bus_write_o` one cycle later, with the same address and direction. While unprotected, every accepted access is allowed.
- R7: During reset `prot_o` follows `nv_secure_i`. A `sec_set_i` pulse sets `prot_o` from the next cycle. If an erase finishes in the same cycle, the erase wins.
- R8: An `erase_req_i` seen while idle raises `ram_wipe_o` from the next cycle. It stays high until a `ram_done_i` is sampled. `flash_wipe_o` is then high until a `flash_done_i` is sampled, and `prot_o` clears at that same edge. An `erase_req_i` seen while an erase is running is ignored.
- R9: `prot_o` falls only at the end of the flash phase of R8. A `ram_done_i` or `flash_done_i` outside its own phase has no effect.
- R10: `rext_o` is set by `rext_set_i` at all times. It is cleared by `rext_clr_i` only while unprotected. When both arrive together, set wins.
- R11: `attach_ok_o` pulses one cycle after `attach_req_i` if `attach_cold_i`=1 or the device is unprotected. A hot attach (`attach_cold_i`=0) while protected gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_secure_i | input | 1 | Non-volatile security state loaded during reset |
| sec_set_i | input | 1 | One-cycle pulse that enables protection |
| erase_req_i | input | 1 | Full erase request |
| ram_done_i | input | 1 | Volatile memory wipe finished |
| flash_done_i | input | 1 | Flash wipe finished |
| ram_wipe_o | output | 1 | Volatile memory wipe in progress |
| flash_wipe_o | output | 1 | Flash wipe in progress |
| prot_o | output | 1 | Device protected |
| acc_valid_i | input | 1 | Access request |
| acc_cpu_i | input | 1 | Access comes from the CPU |
| acc_addr_i | input | AW | Access address |
| acc_write_i | input | 1 | Access is a write |
| acc_ready_o | output | 1 | Ready; low in the first error cycle |
| acc_err_o | output | 1 | Error response flag |
| bus_valid_o | output | 1 | Forwarded access valid |
| bus_addr_o | output | AW | Forwarded address |
| bus_write_o | output | 1 | Forwarded direction |
| reg_hit_o | output | 1 | Forwarded access hits the register block |
| reg_ofs_o | output | VIEW_W | Register offset inside a view |
| reg_ext_o | output | 1 | Upper (debugger) view used |
| rext_set_i | input | 1 | Assert CPU reset extension |
| rext_clr_i | input | 1 | Clear CPU reset extension |
| rext_o | output | 1 | CPU reset extension held |
| attach_req_i | input | 1 | Debugger attach request |
| attach_cold_i | input | 1 | Attach is a cold plug |
| attach_ok_o | output | 1 | Attach granted |

## Verification
All outputs are registered. A forward, a grant, a reset-extension change, a protection change or an erase phase change appears one clock edge after the input that causes it is sampled. An error response takes the two cycles after the blocked access is accepted. The bench drives inputs just after a rising edge and advances a behavioural model at that same edge. It compares every output with the model at the following falling edge, so each result is checked in exactly the cycle it is due. Directed sequences hit the window edges and an erase that unlocks the device, and a random phase follows them.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    typedef enum logic [1:0] {ER_IDLE, ER_RAM, ER_FLASH} erase_st_t;
    typedef enum logic [1:0] {EP_NONE, EP_HOLD, EP_TAIL} err_ph_t;
endpackage

// File: rtl/dsf_decode.sv
module dsf_decode #(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   DSU_BASE = 'h4100_2000,
    parameter int              DSU_SPAN = 'h2000,
    parameter int              VIEW_W   = 8
) (
    input  logic [AW-1:0]     addr_i,
    input  logic              cpu_i,
    input  logic              prot_i,
    output logic              allow_o,
    output logic              win_ok_o,
    output logic              hit_o,
    output logic [VIEW_W-1:0] ofs_o,
    output logic              ext_o
);
    localparam logic [AW-1:0] LIM_SPAN = AW'(DSU_SPAN);
    localparam logic [AW-1:0] LIM_VIEW = AW'(1) << VIEW_W;
    localparam logic [AW-1:0] LIM_REGS = AW'(2) << VIEW_W;

    logic [AW-1:0] off;

    always_comb begin
        off      = addr_i - DSU_BASE;
        // debugger window: upper view start up to the end of the unit's range
        win_ok_o = (off >= LIM_VIEW) && (off < LIM_SPAN);
        allow_o  = cpu_i || !prot_i || win_ok_o;
        hit_o    = off < LIM_REGS;
        ofs_o    = hit_o ? off[VIEW_W-1:0] : '0;
        ext_o    = hit_o && off[VIEW_W];
    end
endmodule

// File: rtl/dsf_erase.sv
module dsf_erase
    import dsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nv_secure_i,
    input  logic sec_set_i,
    input  logic erase_req_i,
    input  logic ram_done_i,
    input  logic flash_done_i,
    output logic ram_wipe_o,
    output logic flash_wipe_o,
    output logic prot_o
);
    typedef struct packed {
        erase_st_t st;
        logic      prot;
    } er_regs_t;

    er_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ER_IDLE:  if (erase_req_i)  r_d.st = ER_RAM;
            ER_RAM:   if (ram_done_i)   r_d.st = ER_FLASH;
            ER_FLASH: if (flash_done_i) r_d.st = ER_IDLE;
            default:                    r_d.st = ER_IDLE;
        endcase
        if (r_q.st == ER_FLASH && flash_done_i) r_d.prot = 1'b0;
        else if (sec_set_i)                     r_d.prot = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ER_IDLE;
            r_q.prot <= nv_secure_i;
        end else begin
            r_q <= r_d;
        end
    end

    assign ram_wipe_o   = (r_q.st == ER_RAM);
    assign flash_wipe_o = (r_q.st == ER_FLASH);
    assign prot_o       = r_q.prot;

    assert_unlock_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_o) |-> ($past(flash_wipe_o) && $past(flash_done_i)));
    assert_flash_after_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_wipe_o) |-> ($past(ram_wipe_o) && $past(ram_done_i)));
endmodule

// File: rtl/dsf_feat.sv
module dsf_feat (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_i,
    input  logic rext_set_i,
    input  logic rext_clr_i,
    input  logic attach_req_i,
    input  logic attach_cold_i,
    output logic rext_o,
    output logic attach_ok_o
);
    typedef struct packed {
        logic rext;
        logic att;
    } ft_regs_t;

    ft_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rext_set_i)                  r_d.rext = 1'b1;
        else if (rext_clr_i && !prot_i)  r_d.rext = 1'b0;
        r_d.att = attach_req_i && (attach_cold_i || !prot_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rext_o      = r_q.rext;
    assign attach_ok_o = r_q.att;

    assert_clr_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_i && rext_clr_i && rext_o) |=> rext_o);
    assert_hot_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_i && attach_req_i && !attach_cold_i) |=> !attach_ok_o);
endmodule

// File: rtl/dbg_sec_filter.sv
module dbg_sec_filter
    import dsf_pkg::*;
#(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   DSU_BASE = 'h4100_2000,
    parameter int              DSU_SPAN = 'h2000,
    parameter int              VIEW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_secure_i,
    input  logic              sec_set_i,
    input  logic              erase_req_i,
    input  logic              ram_done_i,
    input  logic              flash_done_i,
    output logic              ram_wipe_o,
    output logic              flash_wipe_o,
    output logic              prot_o,
    input  logic              acc_valid_i,
    input  logic              acc_cpu_i,
    input  logic [AW-1:0]     acc_addr_i,
    input  logic              acc_write_i,
    output logic              acc_ready_o,
    output logic              acc_err_o,
    output logic              bus_valid_o,
    output logic [AW-1:0]     bus_addr_o,
    output logic              bus_write_o,
    output logic              reg_hit_o,
    output logic [VIEW_W-1:0] reg_ofs_o,
    output logic              reg_ext_o,
    input  logic              rext_set_i,
    input  logic              rext_clr_i,
    output logic              rext_o,
    input  logic              attach_req_i,
    input  logic              attach_cold_i,
    output logic              attach_ok_o
);
    typedef struct packed {
        logic              bv;
        logic [AW-1:0]     ba;
        logic              bw;
        logic              hit;
        logic [VIEW_W-1:0] ofs;
        logic              ext;
        err_ph_t           ph;
    } acc_regs_t;

    acc_regs_t r_d, r_q;

    logic              dec_allow, dec_win, dec_hit, dec_ext, accept, fwd;
    logic [VIEW_W-1:0] dec_ofs;

    dsf_decode #(.AW(AW), .DSU_BASE(DSU_BASE), .DSU_SPAN(DSU_SPAN), .VIEW_W(VIEW_W)) u_dec (
        .addr_i(acc_addr_i), .cpu_i(acc_cpu_i), .prot_i(prot_o),
        .allow_o(dec_allow), .win_ok_o(dec_win), .hit_o(dec_hit),
        .ofs_o(dec_ofs), .ext_o(dec_ext)
    );

    dsf_erase u_er (
        .clk(clk), .rst_n(rst_n), .nv_secure_i(nv_secure_i), .sec_set_i(sec_set_i),
        .erase_req_i(erase_req_i), .ram_done_i(ram_done_i), .flash_done_i(flash_done_i),
        .ram_wipe_o(ram_wipe_o), .flash_wipe_o(flash_wipe_o), .prot_o(prot_o)
    );

    dsf_feat u_ft (
        .clk(clk), .rst_n(rst_n), .prot_i(prot_o), .rext_set_i(rext_set_i),
        .rext_clr_i(rext_clr_i), .attach_req_i(attach_req_i), .attach_cold_i(attach_cold_i),
        .rext_o(rext_o), .attach_ok_o(attach_ok_o)
    );

    always_comb begin
        accept = acc_valid_i && (r_q.ph != EP_HOLD);
        fwd    = accept && dec_allow;
        r_d    = '0;
        if (fwd) begin
            r_d.bv  = 1'b1;
            r_d.ba  = acc_addr_i;
            r_d.bw  = acc_write_i;
            r_d.hit = dec_hit;
            r_d.ofs = dec_ofs;
            r_d.ext = dec_ext;
        end
        if (accept && !dec_allow)   r_d.ph = EP_HOLD;
        else if (r_q.ph == EP_HOLD) r_d.ph = EP_TAIL;
        else                        r_d.ph = EP_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_valid_o = r_q.bv;
    assign bus_addr_o  = r_q.ba;
    assign bus_write_o = r_q.bw;
    assign reg_hit_o   = r_q.hit;
    assign reg_ofs_o   = r_q.ofs;
    assign reg_ext_o   = r_q.ext;
    assign acc_ready_o = (r_q.ph != EP_HOLD);
    assign acc_err_o   = (r_q.ph != EP_NONE);

    assert_block_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_ready_o && !acc_cpu_i && prot_o && !dec_win)
        |=> (!bus_valid_o && !acc_ready_o && acc_err_o));
    assert_err_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready_o |=> (acc_ready_o && acc_err_o));
    assert_stall_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready_o |=> !bus_valid_o);
    assert_cpu_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_ready_o && acc_cpu_i) |=> bus_valid_o);
    assert_open_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_ready_o && !prot_o)
        |=> (bus_valid_o && bus_addr_o == $past(acc_addr_i)));
endmodule

// File: tb/sim_dbg_sec_filter.sv
`timescale 1ns/1ps
module sim_dbg_sec_filter;
    localparam logic [31:0] BASE = 32'h4100_2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic nv_secure_i = 1'b1, sec_set_i = 0, erase_req_i = 0, ram_done_i = 0, flash_done_i = 0;
    logic acc_valid_i = 0, acc_cpu_i = 0, acc_write_i = 0;
    logic [31:0] acc_addr_i = '0;
    logic rext_set_i = 0, rext_clr_i = 0, attach_req_i = 0, attach_cold_i = 0;
    logic ram_wipe_o, flash_wipe_o, prot_o, acc_ready_o, acc_err_o, bus_valid_o, bus_write_o;
    logic reg_hit_o, reg_ext_o, rext_o, attach_ok_o;
    logic [31:0] bus_addr_o;
    logic [7:0]  reg_ofs_o;

    always #2.5 clk = ~clk;

    dbg_sec_filter u0 (.*);

    // behavioural reference state
    int m_prot, m_est, m_err, m_bv, m_bw, m_hit, m_ofs, m_ext, m_rext, m_att;
    logic [31:0] m_ba;
    int vectors = 0, miscompares = 0;
    bit started = 0, done = 0;

    always @(posedge clk) begin
        logic [31:0] off;
        int acc, ok, n_prot, n_est;
        started = 1;
        if (!rst_n) begin
            m_prot = nv_secure_i; m_est = 0; m_err = 0; m_bv = 0; m_ba = 0; m_bw = 0;
            m_hit = 0; m_ofs = 0; m_ext = 0; m_rext = 0; m_att = 0;
        end else begin
            off = acc_addr_i - BASE;
            acc = acc_valid_i && (m_err != 1);
            ok  = acc_cpu_i || !m_prot || (off >= 32'h100 && off < 32'h2000);
            m_bv = acc && ok;
            m_ba = m_bv ? acc_addr_i : 0;
            m_bw = m_bv ? acc_write_i : 0;
            m_hit = m_bv && off < 32'h200;
            m_ofs = m_hit ? int'(off & 32'hFF) : 0;
            m_ext = m_hit ? int'(off[8]) : 0;
            m_err = (acc && !ok) ? 1 : (m_err == 1 ? 2 : 0);
            n_prot = m_prot; n_est = m_est;
            if (m_est == 0 && erase_req_i) n_est = 1;
            else if (m_est == 1 && ram_done_i) n_est = 2;
            else if (m_est == 2 && flash_done_i) begin n_est = 0; n_prot = 0; end
            if (!(m_est == 2 && flash_done_i) && sec_set_i) n_prot = 1;
            if (rext_set_i) m_rext = 1;
            else if (rext_clr_i && !m_prot) m_rext = 0;
            m_att = attach_req_i && (attach_cold_i || !m_prot);
            m_prot = n_prot; m_est = n_est;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (started && !done) begin
        chk("R2 R4 R5 R6 bus_valid", 32'(bus_valid_o), 32'(m_bv));
        chk("R6 bus_addr", bus_addr_o, m_ba);
        chk("R6 bus_write", 32'(bus_write_o), 32'(m_bw));
        chk("R1 reg_hit", 32'(reg_hit_o), 32'(m_hit));
        chk("R1 reg_ofs", 32'(reg_ofs_o), 32'(m_ofs));
        chk("R1 reg_ext", 32'(reg_ext_o), 32'(m_ext));
        chk("R3 R4 ready", 32'(acc_ready_o), 32'(m_err != 1));
        chk("R3 err", 32'(acc_err_o), 32'(m_err != 0));
        chk("R7 R9 prot", 32'(prot_o), 32'(m_prot));
        chk("R8 ram_wipe", 32'(ram_wipe_o), 32'(m_est == 1));
        chk("R8 flash_wipe", 32'(flash_wipe_o), 32'(m_est == 2));
        chk("R10 rext", 32'(rext_o), 32'(m_rext));
        chk("R11 attach", 32'(attach_ok_o), 32'(m_att));
    end

    task automatic cyc();
        @(posedge clk); #1;
        acc_valid_i = 0; sec_set_i = 0; erase_req_i = 0; ram_done_i = 0; flash_done_i = 0;
        rext_set_i = 0; rext_clr_i = 0; attach_req_i = 0;
    endtask

    task automatic acc(logic [31:0] a, logic cpu, logic wr);
        acc_valid_i = 1; acc_addr_i = a; acc_cpu_i = cpu; acc_write_i = wr;
        cyc();
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all) actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; cyc();
        // protected: window edges (R2, R3), R1 views
        acc(BASE + 32'h0FF, 0, 0); cyc();
        acc(BASE + 32'h100, 0, 1);
        acc(BASE + 32'h1FF, 0, 0);
        acc(BASE + 32'h1FFF, 0, 1);
        acc(BASE + 32'h2000, 0, 0);
        acc(BASE + 32'h2000, 0, 0);   // R4: presented while ready is low
        cyc();
        acc(32'h2000_0000, 0, 1); cyc();
        acc(BASE + 32'h010, 1, 0);    // R5 CPU internal view
        acc(32'h2000_0000, 1, 1);     // R5 CPU elsewhere
        // R10, R11 under protection
        rext_set_i = 1; cyc();
        rext_clr_i = 1; cyc();
        attach_req_i = 1; attach_cold_i = 0; cyc();
        attach_req_i = 1; attach_cold_i = 1; cyc();
        // R8 R9 erase, with stray done pulses
        flash_done_i = 1; ram_done_i = 1; cyc();
        erase_req_i = 1; cyc();
        flash_done_i = 1; cyc();
        erase_req_i = 1; cyc();
        ram_done_i = 1; cyc();
        ram_done_i = 1; cyc();
        flash_done_i = 1; sec_set_i = 1; cyc();   // R7 erase wins
        cyc();
        // unprotected: R6
        acc(BASE + 32'h0FF, 0, 1);
        acc(BASE + 32'h2000, 0, 0);
        acc(32'h0000_0004, 0, 1);
        rext_set_i = 1; rext_clr_i = 1; cyc();
        rext_clr_i = 1; cyc();
        attach_req_i = 1; attach_cold_i = 0; cyc();
        sec_set_i = 1; cyc();
        acc(BASE + 32'h0FF, 0, 0); cyc();
        // random phase
        for (int i = 0; i < 2000; i++) begin
            int sel = $urandom_range(0, 7);
            logic [31:0] edges [6] = '{32'h0FF, 32'h100, 32'h1FF, 32'h1FFF, 32'h2000, 32'h0};
            acc_valid_i = $urandom_range(0, 1);
            acc_cpu_i   = ($urandom_range(0, 5) == 0);
            acc_write_i = $urandom_range(0, 1);
            acc_addr_i  = (sel < 6) ? BASE + edges[sel] :
                          (sel == 6) ? BASE + ($urandom & 32'h3FFF) : $urandom;
            sec_set_i    = ($urandom_range(0, 40) == 0);
            erase_req_i  = ($urandom_range(0, 30) == 0);
            ram_done_i   = ($urandom_range(0, 4) == 0);
            flash_done_i = ($urandom_range(0, 4) == 0);
            rext_set_i   = ($urandom_range(0, 6) == 0);
            rext_clr_i   = ($urandom_range(0, 4) == 0);
            attach_req_i = ($urandom_range(0, 3) == 0);
            attach_cold_i = $urandom_range(0, 1);
            cyc();
        end
        repeat (3) cyc();
        finish_run();
    end
endmodule